// File: doc/BRIEF.md
# HDLC Receive Deframer with Frame Status

This block sits behind a bit-clock recovery stage and takes a serial HDLC line stream, one bit per strobe. It searches the stream for flag sequences. It removes the zeros the sender inserted after runs of five ones, and it packs the remaining bits into bytes, least significant bit first. Every byte of a frame goes to the host, in order. The last two bytes of each frame are the frame check sequence, and the host drops them.

A CRC-16 runs over the frame while it arrives. When the frame closes, the block sends one status byte: 'G' for a good check, 'e' for a bad or malformed frame, or 'A' for an abort. The status byte is tagged with `eof_o`, so the host can tell it apart from data. To keep flag bits out of the data, the block always holds back the most recent complete byte. It releases that byte only when the next byte completes or when a correctly aligned closing flag arrives.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, and after any abort, no byte is delivered until a flag (bits 0,1,1,1,1,1,1,0) has been received. Bits that arrive before that flag have no effect on the output.
- R2: A frame starts with the first 8 destuffed bits after a flag that do not themselves complete a flag. Repeated or shared flags between frames deliver nothing.
- R3: Inside a frame, a 0 that follows exactly five consecutive 1s is removed from the stream before bytes are packed.
- R4: Frame bytes are packed least significant bit first and delivered in arrival order, with `eof_o`=0. The two check bytes at the end of the frame are delivered as data.
- R5: On a byte-aligned closing flag, when the frame holds at least 2 bytes and the CRC (reflected polynomial 0x8408, preset 0xFFFF, updated over every frame byte including the two check bytes) equals 0xF0B8, the block delivers the status byte 0x47 ('G') with `eof_o`=1.
- R6: If the frame meets R5's length and alignment conditions but the CRC does not equal 0xF0B8, the status byte is 0x65 ('e').
- R7: A frame with fewer than 2 bytes, or one whose closing flag is not on a byte boundary, ends with status 0x65 ('e'). In the misaligned case, the partial bits and the byte still held back are not delivered.
- R8: Seven consecutive 1s inside a frame are an abort. The block discards the held-back byte, delivers 0x41 ('A') with `eof_o`=1, and returns to flag hunting. Seven 1s between frames deliver nothing.
- R9: `eof_o` is high only together with `byte_valid_o`, for one cycle, once per frame.
- R10: While `rst_ni` is low, `byte_valid_o`, `eof_o` and `byte_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | Line bit strobe |
| bit_i | input | 1 | Line bit value |
| byte_valid_o | output | 1 | Output byte valid, one cycle |
| byte_o | output | 8 | Frame byte, or status code when eof_o is high |
| eof_o | output | 1 | Marks byte_o as the frame status byte |

## Verification
The hardest cases to reach are the moments when a flag or an abort lands while a byte is held back. The first is a closing flag that is not byte-aligned, so that the flag's own bits complete a byte. The second is an abort that arrives after a byte has completed but before it has been released. The stimulus builds these from a stuffing line encoder. For the misaligned case, it appends three loose bits before the flag. For the abort case, it sends a run of ones straight after a byte that ends in zero. The scoreboard then expects the real bytes, with no flag byte and no held-back byte, followed by 'e' or 'A'. Hunt-state rejection is covered by sending a raw zero run after an abort and an alternating pattern after reset. Neither may reach the output.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ST_GOOD  = 8'h47;
  localparam logic [BYTE_W-1:0] ST_BAD   = 8'h65;
  localparam logic [BYTE_W-1:0] ST_ABORT = 8'h41;
  localparam logic [15:0] FCS_PRESET  = 16'hFFFF;
  localparam logic [15:0] FCS_RESIDUE = 16'hF0B8;
  localparam logic [15:0] FCS_POLY    = 16'h8408;

  typedef enum logic {RX_HUNT, RX_ACTIVE} rx_state_e;

  function automatic logic [15:0] fcs_byte(input logic [15:0] crc,
                                           input logic [BYTE_W-1:0] data);
    logic [15:0] r;
    r = crc;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0] ^ data[i]) r = (r >> 1) ^ FCS_POLY;
      else                r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/hdlc_destuff.sv
module hdlc_destuff #(
  parameter int unsigned FLAG_RUN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_valid_i,
  input  logic bit_i,
  output logic dbit_valid_o,
  output logic dbit_o,
  output logic flag_o,
  output logic abort_o
);
  localparam int unsigned ONES_MAX = FLAG_RUN + 1;
  localparam int unsigned ONES_W   = $clog2(ONES_MAX + 1);

  logic [ONES_W-1:0] ones_q;

  always_comb begin
    dbit_valid_o = 1'b0;
    flag_o       = 1'b0;
    abort_o      = 1'b0;
    dbit_o       = bit_i;
    if (bit_valid_i) begin
      if (bit_i) begin
        if (ones_q == ONES_W'(FLAG_RUN))     abort_o      = 1'b1;
        else if (ones_q < ONES_W'(FLAG_RUN)) dbit_valid_o = 1'b1;
      end else begin
        if (ones_q == ONES_W'(FLAG_RUN))          flag_o       = 1'b1;
        else if (ones_q != ONES_W'(FLAG_RUN - 1)) dbit_valid_o = 1'b1;
        // zero after five ones: stuffed, dropped
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ones_q <= '0;
    else if (bit_valid_i) begin
      if (!bit_i)                             ones_q <= '0;
      else if (ones_q != ONES_W'(ONES_MAX))   ones_q <= ones_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_packer.sv
module hdlc_packer #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  output logic             done_o,
  output logic [WIDTH-1:0] byte_o,
  output logic [$clog2(WIDTH)-1:0] cnt_o
);
  localparam int unsigned CNT_W = $clog2(WIDTH);

  logic [WIDTH-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;

  assign byte_o = {bit_i, sh_q[WIDTH-1:1]};
  assign done_o = bit_valid_i && !clr_i && (cnt_q == CNT_W'(WIDTH - 1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (bit_valid_i) begin
      sh_q  <= byte_o;
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_fcs.sv
module hdlc_fcs
  import hdlc_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [15:0]       crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_o <= FCS_PRESET;
    else if (clr_i) crc_o <= FCS_PRESET;
    else if (upd_i) crc_o <= fcs_byte(crc_o, data_i);
  end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned FLAG_RUN = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              eof_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  rx_state_e         state_q;
  logic              dbit_valid, dbit, flag_e, abort_e;
  logic              active, pk_valid, pk_clr, pk_done, aligned;
  logic [BYTE_W-1:0] pk_byte, held_q, stat_code_q;
  logic [CNT_W-1:0]  pk_cnt;
  logic [1:0]        bytes_q;
  logic              stat_pend_q, fcs_upd, fcs_ok;
  logic [15:0]       crc;

  hdlc_destuff #(.FLAG_RUN(FLAG_RUN)) u_destuff (
    .clk_i, .rst_ni, .bit_valid_i, .bit_i,
    .dbit_valid_o(dbit_valid), .dbit_o(dbit), .flag_o(flag_e), .abort_o(abort_e)
  );

  assign active   = (state_q == RX_ACTIVE);
  assign pk_valid = dbit_valid && active;
  assign pk_clr   = !active || flag_e || abort_e;

  hdlc_packer #(.WIDTH(BYTE_W)) u_packer (
    .clk_i, .rst_ni, .clr_i(pk_clr), .bit_valid_i(pk_valid), .bit_i(dbit),
    .done_o(pk_done), .byte_o(pk_byte), .cnt_o(pk_cnt)
  );

  assign fcs_upd = pk_done && (bytes_q != 2'd0);

  hdlc_fcs u_fcs (
    .clk_i, .rst_ni, .clr_i(flag_e || abort_e), .upd_i(fcs_upd),
    .data_i(held_q), .crc_o(crc)
  );

  // flag bits 0111111 already entered the packer when the flag resolves
  assign aligned = (pk_cnt == CNT_W'(BYTE_W - 1));
  assign fcs_ok  = (fcs_byte(crc, held_q) == FCS_RESIDUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= RX_HUNT;
      held_q       <= '0;
      bytes_q      <= '0;
      stat_pend_q  <= 1'b0;
      stat_code_q  <= '0;
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
      eof_o        <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      eof_o        <= 1'b0;
      if (stat_pend_q) begin
        byte_valid_o <= 1'b1;
        byte_o       <= stat_code_q;
        eof_o        <= 1'b1;
        stat_pend_q  <= 1'b0;
      end
      if (abort_e) begin
        state_q <= RX_HUNT;
        bytes_q <= '0;
        if (active && bytes_q != 2'd0) begin
          stat_pend_q <= 1'b1;
          stat_code_q <= ST_ABORT;
        end
      end else if (flag_e) begin
        state_q <= RX_ACTIVE;
        bytes_q <= '0;
        if (active && bytes_q != 2'd0) begin
          if (aligned) begin
            byte_valid_o <= 1'b1;
            byte_o       <= held_q;
          end
          stat_pend_q <= 1'b1;
          stat_code_q <= (aligned && bytes_q == 2'd2 && fcs_ok) ? ST_GOOD : ST_BAD;
        end
      end else if (pk_done) begin
        held_q <= pk_byte;
        if (bytes_q != 2'd0) begin
          byte_valid_o <= 1'b1;
          byte_o       <= held_q;
        end
        if (bytes_q != 2'd2) bytes_q <= bytes_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk
  import hdlc_rx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_valid_o,
  input logic [BYTE_W-1:0] byte_o,
  input logic              eof_o,
  input rx_state_e         state_q,
  input logic              stat_pend_q,
  input logic              abort_e
);
  AST_EOF_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> byte_valid_o); // R9
  AST_EOF_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o); // R9
  AST_EOF_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> (byte_o == ST_GOOD || byte_o == ST_BAD || byte_o == ST_ABORT)); // R5
  AST_HUNT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_HUNT && !stat_pend_q) |=> !byte_valid_o); // R1
  AST_ABORT_HUNTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_e |=> (state_q == RX_HUNT)); // R8
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_valid_o(byte_valid_o), .byte_o(byte_o),
  .eof_o(eof_o), .state_q(state_q), .stat_pend_q(stat_pend_q), .abort_e(abort_e)
);

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bv = 1'b0;
  logic       bd = 1'b0;
  logic       byte_valid;
  logic [7:0] byte_q;
  logic       eof;

  int checks = 0;
  int errors = 0;
  int nbits = 0;
  int tx_ones = 0;
  bit finished = 1'b0;

  logic [8:0] exp_q[$];
  int         req_q[$];
  logic [7:0] pay[$];

  always #10 clk = ~clk;

  hdlc_rx_deframer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_valid_i(bv), .bit_i(bd),
    .byte_valid_o(byte_valid), .byte_o(byte_q), .eof_o(eof)
  );

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    logic fb;
    for (int k = 0; k < 8; k++) begin
      fb = r[0] ^ d[k];
      r  = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic expect_item(input logic e, input logic [7:0] b, input int req);
    exp_q.push_back({e, b});
    req_q.push_back(req);
  endtask

  // one line bit; occasional idle gaps between strobes
  task automatic send_bit(input logic b);
    bv = 1'b1;
    bd = b;
    @(negedge clk);
    nbits++;
    if (nbits % 7 == 3) begin
      bv = 1'b0;
      @(negedge clk);
    end
    bv = 1'b0;
  endtask

  task automatic send_stuffed(input logic b);
    send_bit(b);
    tx_ones = b ? tx_ones + 1 : 0;
    if (tx_ones == 5) begin
      send_bit(1'b0); // R3 inserted zero
      tx_ones = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) send_stuffed(d[i]);
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    tx_ones = 0;
  endtask

  // frame from pay[], closing flag included; R4 data, R5 or R6 status
  task automatic send_frame(input bit corrupt);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    foreach (pay[i]) begin
      expect_item(1'b0, pay[i], 4);
      c = ref_crc(c, pay[i]);
    end
    fcs = ~c;
    if (corrupt) fcs[3] = ~fcs[3];
    expect_item(1'b0, fcs[7:0], 4);
    expect_item(1'b0, fcs[15:8], 4);
    expect_item(1'b1, corrupt ? 8'h65 : 8'h47, corrupt ? 6 : 5);
    foreach (pay[i]) send_byte(pay[i]);
    send_byte(fcs[7:0]);
    send_byte(fcs[15:8]);
    send_flag();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (eof && !byte_valid) begin
        checks++; errors++;
        $display("FAIL R9: eof_o=1 with byte_valid_o=0 expected 0");
      end
      if (byte_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R1/R2: unexpected eof=%0b byte=%02h expected none", eof, byte_q);
        end else begin
          logic [8:0] e;
          int r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          if ({eof, byte_q} !== e) begin
            errors++;
            $display("FAIL R%0d: got eof=%0b byte=%02h expected eof=%0b byte=%02h",
                     r, eof, byte_q, e[8], e[7:0]);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    checks++;
    if (byte_valid !== 1'b0 || eof !== 1'b0 || byte_q !== 8'h00) begin
      errors++;
      $display("FAIL R10: got v=%0b eof=%0b byte=%02h expected 0 0 00", byte_valid, eof, byte_q);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 hunt: ones and alternating bits, no flag, nothing out
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    for (int i = 0; i < 24; i++) send_bit(1'(i % 2));

    // R2 repeated flags deliver nothing, then good frames sharing flags
    send_flag(); send_flag(); send_flag();
    pay = '{8'h01, 8'hA5, 8'h3C};
    send_frame(1'b0);
    // R3 stuffing-heavy payload, shared flag
    pay = '{8'hFF, 8'hFF, 8'h7E, 8'h3E, 8'h1F};
    send_frame(1'b0);

    // R6 corrupted check bytes
    pay = '{8'h10, 8'h20, 8'h30};
    send_frame(1'b1);

    // R7 short frame: one byte then flag
    expect_item(1'b0, 8'h12, 7);
    expect_item(1'b1, 8'h65, 7);
    send_byte(8'h12);
    send_flag();

    // R7 misaligned closing flag: 3 loose bits
    expect_item(1'b0, 8'h11, 7);
    expect_item(1'b0, 8'h22, 7);
    expect_item(1'b1, 8'h65, 7);
    send_byte(8'h11);
    send_byte(8'h22);
    send_stuffed(1'b1); send_stuffed(1'b0); send_stuffed(1'b1);
    send_flag();

    // R8 abort inside frame: held 0x77 dropped
    expect_item(1'b0, 8'h5A, 8);
    expect_item(1'b0, 8'h66, 8);
    expect_item(1'b1, 8'h41, 8);
    send_byte(8'h5A);
    send_byte(8'h66);
    send_byte(8'h77);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    // R8 hunt after abort: raw zeros ignored
    for (int i = 0; i < 16; i++) send_bit(1'b0);
    send_flag();
    pay = '{8'h42};
    send_frame(1'b0);

    // R8 abort between frames delivers nothing
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    send_flag();
    pay.delete();
    for (int i = 0; i < 20; i++) pay.push_back(8'((i * 37) ^ 8'h5C));
    send_frame(1'b0);
    pay = '{8'h00, 8'hFE};
    send_frame(1'b1);

    repeat (20) @(negedge clk);
    checks++; // R9 one status per frame, all expected items seen
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: got %0d items left expected 0", exp_q.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule